// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block gives a processor core two 32-bit event counters and one control register, all reachable through a small register port. Each counter has its own 6-bit event select field in the control register. Code 0 counts clock cycles. Codes 1 to NUM_EVT count pulses from the event vector. One reserved code per counter counts retirements of a dedicated marker NOP, which never occurs in normal code. Software points an unused counter at that code to keep it idle.

The counters have no individual enables. A user-context bit and a supervisor-context bit gate both counters together, based on the current privilege mode. When a counter wraps from all ones to zero, a sticky pending flag is set and drives the interrupt output. Software can preload a counter with the negated sample period, so the interrupt fires after exactly that many qualifying events. Both counters are read and written as one 64-bit word, with a byte-lane style strobe for each 32-bit half.

Top module: `dual_ctr_pmu`

## Requirements
- R1: Synchronous active-low reset clears both counters, every control field and the pending flag, so `irq` reads 0.
- R2: With `rd_sel`=1, `rd_data` shows the upper counter in bits 63:32 and the lower counter in bits 31:0. A write with `wr_sel`=1 loads a half only when its strobe is set (`wr_strb[1]` for the upper half, `wr_strb[0]` for the lower half). A half whose strobe is clear keeps its value.
- R3: Select code 0x00 adds one to the counter on every clock edge at which counting is enabled.
- R4: Select code c in the range 1..NUM_EVT counts pulses of `evt_vec[c-1]`. Code 0x01 is therefore retired instructions on `evt_vec[0]`.
- R5: Code 0x1C on the upper counter and code 0x14 on the lower counter count `marker_ret` pulses. Each of these codes counts nothing when it is placed on the other counter.
- R6: Any other select code counts nothing.
- R7: Counting is enabled only when the context bit that matches `priv_sup` is set. Control bit 1 applies when `priv_sup`=1 (supervisor). Control bit 2 applies when `priv_sup`=0 (user). When both bits are clear, neither counter moves.
- R8: An increment that takes a counter from 0xFFFFFFFF to 0 leaves the counter at 0 and sets the pending flag (control bit 0). The pending flag drives `irq`.
- R9: The pending flag stays set until a control write with bit 0 equal to 0 clears it. Writing 1 to bit 0 has no effect. A wrap on the same edge as a clearing write leaves the flag set.
- R10: A counter write takes effect on its edge and replaces any increment on that edge. A write on an edge where the counter would wrap does not set the pending flag.
- R11: After a counter is loaded with the two's complement of P, `irq` rises on the P-th qualifying event and not before it.
- R12: With `rd_sel`=0, `rd_data` shows the pending flag at bit 0, the supervisor enable at bit 1, the user enable at bit 2, the lower select at bits 9:4 and the upper select at bits 16:11. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 counter word |
| wr_strb | input | 2 | Counter half strobes: bit 1 upper, bit 0 lower |
| wr_data | input | 64 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 counter word |
| rd_data | output | 64 | Combinational read data |
| evt_vec | input | NUM_EVT | Single-cycle event pulses; bit 0 is instruction retired |
| marker_ret | input | 1 | Marker NOP retired pulse |
| priv_sup | input | 1 | Current mode: 1 supervisor, 0 user |
| irq | output | 1 | Overflow interrupt, the sticky pending flag |

## Verification
The bench loads a counter to one or two counts below the wrap point and checks that `irq` rises on exactly the edge of the wrap. A design with an off-by-one compare would fire early or late. It also lands a clearing control write on the wrap edge, where a design that lets the clear win would lose the interrupt. It places a counter write on a wrapping edge, which catches a design that raises a false overflow or adds the increment on top of the written value. The marker codes are placed on the wrong counters, and the mode input is set against the enable bit. A design that decodes the codes on both counters, or gates with the wrong context bit, would then show counts where none are expected.

// File: rtl/pmu_pkg.sv
// Shared constants for the dual-counter performance monitor.
// Assumes two 32-bit counters packed into one 64-bit word.
package pmu_pkg;
    localparam int CNT_W      = 32;
    localparam int NUM_CNT    = 2;
    localparam int SEL_W      = 6;
    localparam int PEND_BIT   = 0;
    localparam int SUP_BIT    = 1;
    localparam int USR_BIT    = 2;
    localparam int LO_SEL_LSB = 4;
    localparam int UP_SEL_LSB = 11;
    localparam int CTL_W      = UP_SEL_LSB + SEL_W;
    localparam logic [SEL_W-1:0] CODE_CYCLES = 6'h00;
    localparam logic [SEL_W-1:0] MARK_LO     = 6'h14;
    localparam logic [SEL_W-1:0] MARK_UP     = 6'h1C;
endpackage

// File: rtl/pmu_evt_sel.sv
// Event selector for one counter: turns a select code into a one-cycle
// count request. Assumes NUM_EVT stays below the marker codes.
module pmu_evt_sel
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter logic [SEL_W-1:0] MARK_CODE = MARK_LO
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] evt_vec,
    input  logic               marker_ret,
    output logic               hit
);
    // Decode the select code; unassigned codes count nothing.
    always_comb begin
        hit = 1'b0;
        if (sel == CODE_CYCLES) begin
            hit = 1'b1;
        end else if (sel == MARK_CODE) begin
            hit = marker_ret;
        end else begin
            for (int k = 0; k < NUM_EVT; k++) begin
                if (sel == SEL_W'(k + 1)) hit = evt_vec[k];
            end
        end
    end
endmodule

// File: rtl/pmu_counter.sv
// One 32-bit event counter. A write replaces the increment on the same
// edge. The wrap flag marks an increment from all ones to zero.
module pmu_counter
    import pmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    // Flag the edge on which an increment rolls the counter over.
    always_comb wrap = inc && !wr && (count == {CNT_W{1'b1}});

    // Counter register: reset, write, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (wr)  count <= wr_val;
        else if (inc) count <= count + 1'b1;
    end

    assert_wr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (count == $past(wr_val)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr) |=> $stable(count));
endmodule

// File: rtl/dual_ctr_pmu.sv
// Dual-counter performance monitor: control register, shared context
// gating, two event selectors and counters, and a sticky overflow flag.
// Assumes the register port is written at most once per cycle.
module dual_ctr_pmu
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [1:0]         wr_strb,
    input  logic [63:0]        wr_data,
    input  logic               rd_sel,
    output logic [63:0]        rd_data,
    input  logic [NUM_EVT-1:0] evt_vec,
    input  logic               marker_ret,
    input  logic               priv_sup,
    output logic               irq
);
    localparam int VIEW_W = NUM_CNT * CNT_W;

    logic                         pend_q, sup_en_q, usr_en_q;
    logic [NUM_CNT-1:0][SEL_W-1:0] sel_q;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_CNT-1:0]            hit, inc, cnt_wr, wrap;
    logic                          ctl_wr, clr_req, ctx_en;
    logic [CTL_W-1:0]              ctl_view;

    // Decode register writes and the shared context gate.
    always_comb begin
        ctl_wr  = wr_en && !wr_sel;
        clr_req = ctl_wr && !wr_data[PEND_BIT];
        ctx_en  = priv_sup ? sup_en_q : usr_en_q;
    end

    // Control fields; a wrap sets the pending flag ahead of a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            sup_en_q <= 1'b0;
            usr_en_q <= 1'b0;
            sel_q    <= '0;
        end else begin
            if (|wrap)        pend_q <= 1'b1;
            else if (clr_req) pend_q <= 1'b0;
            if (ctl_wr) begin
                sup_en_q <= wr_data[SUP_BIT];
                usr_en_q <= wr_data[USR_BIT];
                sel_q[0] <= wr_data[LO_SEL_LSB +: SEL_W];
                sel_q[1] <= wr_data[UP_SEL_LSB +: SEL_W];
            end
        end
    end

    // Index 0 is the lower counter and index 1 the upper counter.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam logic [SEL_W-1:0] MK = (i == 1) ? MARK_UP : MARK_LO;

        pmu_evt_sel #(.NUM_EVT(NUM_EVT), .MARK_CODE(MK)) u_sel (
            .sel        (sel_q[i]),
            .evt_vec    (evt_vec),
            .marker_ret (marker_ret),
            .hit        (hit[i])
        );

        // Gate the request with the context enable and decode the half write.
        always_comb begin
            inc[i]    = ctx_en && hit[i];
            cnt_wr[i] = wr_en && wr_sel && wr_strb[i];
        end

        pmu_counter u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc[i]),
            .wr     (cnt_wr[i]),
            .wr_val (wr_data[i*CNT_W +: CNT_W]),
            .count  (cnt_q[i]),
            .wrap   (wrap[i])
        );
    end

    // Assemble the control view and the read mux.
    always_comb begin
        ctl_view = {sel_q[1], 1'b0, sel_q[0], 1'b0, usr_en_q, sup_en_q, pend_q};
        rd_data  = rd_sel ? VIEW_W'(cnt_q) : 64'(ctl_view);
        irq      = pend_q;
    end

    assert_wrap_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> pend_q);

    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_req) |=> pend_q);

    assert_ctx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_en && !(|cnt_wr)) |=> $stable(cnt_q));

    assert_sel_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hit) && !(|cnt_wr)) |=> $stable(cnt_q));
endmodule

// File: tb/sim_dual_ctr_pmu.sv
`timescale 1ns/1ps
module sim_dual_ctr_pmu;
    localparam int NE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [1:0]    wr_strb = '0;
    logic [63:0]   wr_data = '0;
    logic [63:0]   rd_data;
    logic [NE-1:0] evt_vec = '0;
    logic          marker_ret = 1'b0, priv_sup = 1'b1;
    logic          irq;
    int            n_chk = 0, n_bad = 0;
    bit            done = 0;

    always #2 clk = ~clk;

    dual_ctr_pmu #(.NUM_EVT(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_strb(wr_strb), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .evt_vec(evt_vec), .marker_ret(marker_ret),
        .priv_sup(priv_sup), .irq(irq)
    );

    function automatic logic [63:0] mk_ctl(input logic usr, input logic sup,
            input logic [5:0] up, input logic [5:0] lo, input logic keep);
        logic [63:0] v = '0;
        v[0] = keep; v[1] = sup; v[2] = usr;
        v[9:4] = lo; v[16:11] = up;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic sel, input logic [1:0] strb, input logic [63:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_strb = strb; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [NE-1:0] v, input logic mk, input int n);
        evt_vec = v; marker_ret = mk;
        repeat (n) @(negedge clk);
        evt_vec = '0; marker_ret = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [63:0] v);
        rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic off();
        do_wr(0, 2'b00, mk_ctl(0, 0, 6'h3F, 6'h3F, 1));
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(1, v); chk("R1 counters after reset", v, 64'h0);
        rd(0, v); chk("R1 control after reset", v, 64'h0);
        chk("R1 irq after reset", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_ctl_layout();
        logic [63:0] v;
        do_wr(1, 2'b11, 64'h0);
        do_wr(0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(0, v); chk("R12 control field layout", v, 64'h1FBF6);
        pulse('1, 1'b1, 3);
        rd(1, v); chk("R6 unassigned code 0x3F counts nothing", v, 64'h0);
        off();
    endtask

    task automatic t_packed();
        logic [63:0] v;
        do_wr(1, 2'b11, 64'h1234_5678_9ABC_DEF0);
        rd(1, v); chk("R2 full 64-bit write", v, 64'h1234_5678_9ABC_DEF0);
        do_wr(1, 2'b01, 64'hAAAA_AAAA_5555_5555);
        rd(1, v); chk("R2 lower-half write only", v, 64'h1234_5678_5555_5555);
        do_wr(1, 2'b10, 64'hAAAA_AAAA_0000_0000);
        rd(1, v); chk("R2 upper-half write only", v, 64'hAAAA_AAAA_5555_5555);
    endtask

    task automatic t_cycles();
        logic [63:0] v;
        do_wr(1, 2'b11, 64'h0);
        priv_sup = 1'b1;
        do_wr(0, 2'b00, mk_ctl(0, 1, 6'h00, 6'h00, 1));
        idle(6);
        off();
        rd(1, v); chk("R3 cycle code counts 7 edges", v, 64'h7_0000_0007);
    endtask

    task automatic t_events();
        logic [63:0] v;
        do_wr(1, 2'b11, 64'h0);
        do_wr(0, 2'b00, mk_ctl(0, 1, 6'h01, 6'h03, 1));
        pulse(8'b0000_0100, 1'b0, 2);
        pulse(8'b0000_0001, 1'b0, 3);
        pulse(8'b0000_0010, 1'b0, 2);
        off();
        rd(1, v); chk("R4 upper code 0x01 and lower code 0x03", v, 64'h3_0000_0002);
    endtask

    task automatic t_marker();
        logic [63:0] v;
        do_wr(1, 2'b11, 64'h0);
        do_wr(0, 2'b00, mk_ctl(0, 1, 6'h1C, 6'h14, 1));
        pulse('1, 1'b0, 2);
        pulse('0, 1'b1, 3);
        off();
        rd(1, v); chk("R5 marker codes count marker only", v, 64'h3_0000_0003);
        do_wr(1, 2'b11, 64'h0);
        do_wr(0, 2'b00, mk_ctl(0, 1, 6'h14, 6'h1C, 1));
        pulse('0, 1'b1, 4);
        off();
        rd(1, v); chk("R5 swapped marker codes count nothing", v, 64'h0);
    endtask

    task automatic t_context();
        logic [63:0] v;
        do_wr(1, 2'b11, 64'h0);
        priv_sup = 1'b1;
        do_wr(0, 2'b00, mk_ctl(1, 0, 6'h00, 6'h00, 1));
        idle(5);
        off();
        rd(1, v); chk("R7 user enable ignored in supervisor", v, 64'h0);
        priv_sup = 1'b0;
        do_wr(0, 2'b00, mk_ctl(1, 0, 6'h00, 6'h00, 1));
        idle(3);
        off();
        rd(1, v); chk("R7 user enable counts in user mode", v, 64'h4_0000_0004);
        priv_sup = 1'b1;
        do_wr(0, 2'b00, mk_ctl(0, 0, 6'h00, 6'h00, 1));
        idle(4);
        off();
        rd(1, v); chk("R7 both enables clear stops counting", v, 64'h4_0000_0004);
    endtask

    task automatic t_overflow();
        logic [63:0] v;
        priv_sup = 1'b1;
        do_wr(1, 2'b11, 64'h0000_0000_FFFF_FFFD);
        do_wr(0, 2'b00, mk_ctl(0, 1, 6'h1C, 6'h00, 1));
        idle(2);
        rd(1, v); chk("R8 counter at all ones before wrap", v, 64'h0000_0000_FFFF_FFFF);
        chk("R8 irq low before wrap", {63'h0, irq}, 64'h0);
        idle(1);
        rd(1, v); chk("R8 counter wrapped to zero", v, 64'h0);
        chk("R8 irq raised on wrap", {63'h0, irq}, 64'h1);
        off();
        idle(3);
        chk("R9 pending stays set", {63'h0, irq}, 64'h1);
        rd(0, v); chk("R9 pending visible at control bit 0", {63'h0, v[0]}, 64'h1);
        do_wr(0, 2'b00, mk_ctl(0, 0, 6'h3F, 6'h3F, 1));
        chk("R9 writing 1 keeps pending", {63'h0, irq}, 64'h1);
        do_wr(0, 2'b00, mk_ctl(0, 0, 6'h3F, 6'h3F, 0));
        chk("R9 writing 0 clears pending", {63'h0, irq}, 64'h0);
        do_wr(0, 2'b00, mk_ctl(0, 0, 6'h3F, 6'h3F, 1));
        chk("R9 writing 1 does not set pending", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_clear_race();
        do_wr(1, 2'b11, 64'h0000_0000_FFFF_FFFE);
        do_wr(0, 2'b00, mk_ctl(0, 1, 6'h1C, 6'h00, 1));
        idle(1);
        do_wr(0, 2'b00, mk_ctl(0, 1, 6'h1C, 6'h00, 0));
        chk("R9 wrap wins over clear on same edge", {63'h0, irq}, 64'h1);
        do_wr(0, 2'b00, mk_ctl(0, 0, 6'h3F, 6'h3F, 0));
        chk("R9 later clear succeeds", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_period();
        logic [63:0] v;
        priv_sup = 1'b0;
        do_wr(1, 2'b11, 64'h0000_0000_FFFF_FFFB);
        do_wr(0, 2'b00, mk_ctl(1, 0, 6'h1C, 6'h01, 1));
        pulse(8'h01, 1'b0, 4);
        chk("R11 no irq after 4 of 5 events", {63'h0, irq}, 64'h0);
        idle(2);
        pulse(8'h01, 1'b0, 1);
        chk("R11 irq on 5th event", {63'h0, irq}, 64'h1);
        rd(1, v); chk("R11 counter zero at period end", v, 64'h0);
        off();
        do_wr(0, 2'b00, mk_ctl(0, 0, 6'h3F, 6'h3F, 0));
        priv_sup = 1'b1;
    endtask

    task automatic t_write_wins();
        logic [63:0] v;
        do_wr(1, 2'b11, 64'h0);
        do_wr(0, 2'b00, mk_ctl(0, 1, 6'h1C, 6'h00, 1));
        idle(2);
        do_wr(1, 2'b01, 64'h0000_0000_0000_0100);
        rd(1, v); chk("R10 write replaces increment", v, 64'h0000_0000_0000_0100);
        off();
        do_wr(1, 2'b01, 64'h0000_0000_FFFF_FFFF);
        do_wr(0, 2'b00, mk_ctl(0, 1, 6'h1C, 6'h00, 1));
        do_wr(1, 2'b01, 64'h0000_0000_0000_0005);
        rd(1, v); chk("R10 write on wrapping edge", v, 64'h5);
        chk("R10 no pending from suppressed wrap", {63'h0, irq}, 64'h0);
        off();
    endtask

    task automatic t_reset_mid();
        logic [63:0] v;
        do_wr(1, 2'b11, 64'h0000_0000_FFFF_FFFF);
        do_wr(0, 2'b00, mk_ctl(1, 1, 6'h00, 6'h00, 1));
        idle(2);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        rd(1, v); chk("R1 counters cleared by reset", v, 64'h0);
        rd(0, v); chk("R1 control cleared by reset", v, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctl_layout();
        t_packed();
        t_cycles();
        t_events();
        t_marker();
        t_context();
        t_overflow();
        t_clear_race();
        t_period();
        t_write_wins();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule